// File: doc/BRIEF.md
# Receiver Event Status and Interrupt Register Block

This block collects error and event indications from the decoder of a digital audio receiver. It shows them to a host processor as two 8-bit status registers, each paired with an interrupt-enable register. The host reaches all four registers over an 8-bit parallel bus with an active-low chip select and a read/write strobe.

Status register A mixes three kinds of bit:
- live copies of two buffer flags,
- an edge-qualified latch for the third buffer flag,
- sticky latches for slip, CRC failure and channel-status change.

The sticky latches hold until the host reads register A. Status register B shows the decoder's error conditions as live levels.

The block drives an active-low interrupt request for an open-drain pin. It also drives an error flag that summarises the enabled error conditions.

A read of register A clears only the bits that were already latched when the read started. An event that arrives while the read is in progress therefore stays visible for the next read.

Top module: `rx_evt_regs`

## Requirements
- R1: After reset both enable registers read 0x00, no sticky bit is set, irq_no is high and err_o is low.
- R2: Status A sticky bits (bit 2 buffer-flag-2 rise, bit 3 slip, bit 4 CRC error, bit 5 channel-status change) set in the cycle after their event input is high, and stay set until a read of status A completes.
- R3: A read of status A (chip select low, rd_wr_i high, address 0, held for one or more cycles) returns the sticky bits as they stood when the read began. When the strobe drops, it clears only those bits; an event arriving during the read stays latched.
- R4: Status A bit 2 latches only on a low-to-high change of flag2_i; a flag2_i held high after a clear does not set it again.
- R5: A slip event sets status A bit 3 only while slave_i is high; with slave_i low the pulse is ignored.
- R6: Status A bits 0 and 1 follow flag0_i and flag1_i live and are not changed by reads.
- R7: Status B is live: bit 0 parity error, bit 1 bi-phase code error, bit 2 validity, bit 3 loss of lock, bit 4 low confidence; bits 7:5 read zero.
- R8: err_o is high when any status B bit is set together with its enable B bit, and status A bit 6 shows the same value.
- R9: irq_no is low (pin pulled) exactly while some status A bit with its enable A bit set, or some status B bit with its enable B bit set, is 1; otherwise it is high (pin released).
- R10: Address map: 0 status A (read only), 1 status B (read only), 4 enable A, 5 enable B (read/write, written on a clock edge with chip select low and rd_wr_i low). Every other address reads 0x00, and writes to it or to a status address change nothing. rdata_o is 0x00 while no read is selected.
- R11: Reserved enable bits (enable A bit 7, enable B bits 7:5) always read zero, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Host chip select, active low |
| rd_wr_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data |
| flag0_i | input | 1 | Buffer flag 0 level |
| flag1_i | input | 1 | Buffer flag 1 level |
| flag2_i | input | 1 | Buffer flag 2 level (edge-qualified) |
| slip_i | input | 1 | Sample slip event pulse |
| slave_i | input | 1 | Audio port runs with external clocks |
| crc_err_i | input | 1 | Channel-status CRC failure pulse |
| cs_chg_i | input | 1 | Channel-status change pulse |
| parity_err_i | input | 1 | Parity error level |
| code_err_i | input | 1 | Bi-phase code error level |
| validity_i | input | 1 | Validity bit level |
| unlock_i | input | 1 | Loss of lock level |
| conf_err_i | input | 1 | Low confidence level |
| err_o | output | 1 | Enabled error summary |
| irq_no | output | 1 | Interrupt, 0 = pull pin low |

## Verification
The assertions assume that every event and level input is synchronous to clk_i. They also assume that a read of status A is a contiguous run of cycles on address 0, so the start and end of a read are single, well-defined edges. The bench changes every input one time unit after a rising edge and holds each event pulse for exactly one cycle. It releases chip select before it changes address or direction, so every bus access has one start edge and one end edge.

// File: rtl/rx_evt_pkg.sv
package rx_evt_pkg;

  typedef logic [7:0] reg8_t;

  // status A bit positions
  localparam int B_FLAG0  = 0;
  localparam int B_FLAG1  = 1;
  localparam int B_F2RISE = 2;
  localparam int B_SLIP   = 3;
  localparam int B_CRC    = 4;
  localparam int B_CSCHG  = 5;
  localparam int B_ERR    = 6;

  // status B bit positions
  localparam int B_PAR    = 0;
  localparam int B_CODE   = 1;
  localparam int B_VALID  = 2;
  localparam int B_UNLOCK = 3;
  localparam int B_CONF   = 4;

  localparam reg8_t STICKY_MASK = 8'h3C;
  localparam reg8_t EN_A_VALID  = 8'h7F;
  localparam reg8_t EN_B_VALID  = 8'h1F;

  // register addresses
  localparam int A_STAT_A = 0;
  localparam int A_STAT_B = 1;
  localparam int A_EN_A   = 4;
  localparam int A_EN_B   = 5;

  function automatic logic any_masked(input reg8_t stat, input reg8_t en);
    return |(stat & en);
  endfunction

  function automatic reg8_t clear_then_set(input reg8_t cur, input reg8_t clr,
                                           input reg8_t set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/rx_evt_capture.sv
module rx_evt_capture
  import rx_evt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  flag2_i,
  input  logic  slip_i,
  input  logic  slave_i,
  input  logic  crc_err_i,
  input  logic  cs_chg_i,
  input  reg8_t clr_mask_i,
  output reg8_t set_vec_o,
  output reg8_t lat_o
);

  logic flag2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag2_q <= 1'b0;
    else         flag2_q <= flag2_i;
  end

  always_comb begin
    set_vec_o           = '0;
    set_vec_o[B_F2RISE] = flag2_i & ~flag2_q;
    set_vec_o[B_SLIP]   = slip_i & slave_i;
    set_vec_o[B_CRC]    = crc_err_i;
    set_vec_o[B_CSCHG]  = cs_chg_i;
  end

  for (genvar i = 0; i < 8; i++) begin : g_bit
    if (STICKY_MASK[i]) begin : g_lat
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= (q & ~clr_mask_i[i]) | set_vec_o[i];
      end
      assign lat_o[i] = q;
    end else begin : g_none
      assign lat_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/rx_evt_host.sv
module rx_evt_host
  import rx_evt_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  reg8_t             wdata_i,
  input  reg8_t             stat_a_i,
  input  reg8_t             stat_b_i,
  output reg8_t             rdata_o,
  output reg8_t             en_a_o,
  output reg8_t             en_b_o,
  output reg8_t             clr_mask_o
);

  localparam logic [ADDR_W-1:0] AD_SA = ADDR_W'(A_STAT_A);
  localparam logic [ADDR_W-1:0] AD_SB = ADDR_W'(A_STAT_B);
  localparam logic [ADDR_W-1:0] AD_EA = ADDR_W'(A_EN_A);
  localparam logic [ADDR_W-1:0] AD_EB = ADDR_W'(A_EN_B);

  logic  sel, wr, rd, rd_a_act, rd_a_q, rd_start, rd_end;
  reg8_t snap_q, en_a_q, en_b_q, view_a;

  assign sel      = ~cs_ni;
  assign wr       = sel & ~rd_wr_i;
  assign rd       = sel & rd_wr_i;
  assign rd_a_act = rd & (addr_i == AD_SA);
  assign rd_start = rd_a_act & ~rd_a_q;
  assign rd_end   = rd_a_q & ~rd_a_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_a_q <= 1'b0;
      snap_q <= '0;
      en_a_q <= '0;
      en_b_q <= '0;
    end else begin
      rd_a_q <= rd_a_act;
      if (rd_start) snap_q <= stat_a_i & STICKY_MASK;
      if (wr && addr_i == AD_EA) en_a_q <= wdata_i & EN_A_VALID;
      if (wr && addr_i == AD_EB) en_b_q <= wdata_i & EN_B_VALID;
    end
  end

  assign clr_mask_o = rd_end ? snap_q : '0;

  // during a read, show the frozen sticky image so the host sees what it clears
  assign view_a = rd_a_q ? ((stat_a_i & ~STICKY_MASK) | snap_q) : stat_a_i;

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      if      (addr_i == AD_SA) rdata_o = view_a;
      else if (addr_i == AD_SB) rdata_o = stat_b_i;
      else if (addr_i == AD_EA) rdata_o = en_a_q;
      else if (addr_i == AD_EB) rdata_o = en_b_q;
    end
  end

  assign en_a_o = en_a_q;
  assign en_b_o = en_b_q;

endmodule

// File: rtl/rx_evt_summary.sv
module rx_evt_summary
  import rx_evt_pkg::*;
(
  input  reg8_t stat_a_raw_i,
  input  reg8_t en_a_i,
  input  reg8_t stat_b_i,
  input  reg8_t en_b_i,
  output logic  err_o,
  output logic  irq_no
);

  reg8_t stat_a_full;

  assign err_o = any_masked(stat_b_i, en_b_i);

  always_comb begin
    stat_a_full        = stat_a_raw_i;
    stat_a_full[B_ERR] = err_o;
  end

  assign irq_no = ~(any_masked(stat_a_full, en_a_i) | err_o);

endmodule

// File: rtl/rx_evt_regs.sv
module rx_evt_regs
  import rx_evt_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              flag0_i,
  input  logic              flag1_i,
  input  logic              flag2_i,
  input  logic              slip_i,
  input  logic              slave_i,
  input  logic              crc_err_i,
  input  logic              cs_chg_i,
  input  logic              parity_err_i,
  input  logic              code_err_i,
  input  logic              validity_i,
  input  logic              unlock_i,
  input  logic              conf_err_i,
  output logic              err_o,
  output logic              irq_no
);

  reg8_t lat_w, set_w, clr_w, en_a_w, en_b_w;
  reg8_t stat_a_raw, stat_a_full, stat_b_w;
  logic  err_w;

  rx_evt_capture u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flag2_i    (flag2_i),
    .slip_i     (slip_i),
    .slave_i    (slave_i),
    .crc_err_i  (crc_err_i),
    .cs_chg_i   (cs_chg_i),
    .clr_mask_i (clr_w),
    .set_vec_o  (set_w),
    .lat_o      (lat_w)
  );

  always_comb begin
    stat_a_raw          = lat_w;
    stat_a_raw[B_FLAG0] = flag0_i;
    stat_a_raw[B_FLAG1] = flag1_i;
    stat_a_full         = stat_a_raw;
    stat_a_full[B_ERR]  = err_w;
    stat_b_w            = '0;
    stat_b_w[B_PAR]     = parity_err_i;
    stat_b_w[B_CODE]    = code_err_i;
    stat_b_w[B_VALID]   = validity_i;
    stat_b_w[B_UNLOCK]  = unlock_i;
    stat_b_w[B_CONF]    = conf_err_i;
  end

  rx_evt_host #(.ADDR_W(ADDR_W)) u_host (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .rd_wr_i    (rd_wr_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .stat_a_i   (stat_a_full),
    .stat_b_i   (stat_b_w),
    .rdata_o    (rdata_o),
    .en_a_o     (en_a_w),
    .en_b_o     (en_b_w),
    .clr_mask_o (clr_w)
  );

  rx_evt_summary u_sum (
    .stat_a_raw_i (stat_a_raw),
    .en_a_i       (en_a_w),
    .stat_b_i     (stat_b_w),
    .en_b_i       (en_b_w),
    .err_o        (err_w),
    .irq_no       (irq_no)
  );

  assign err_o = err_w;

endmodule

// File: rtl/rx_evt_regs_chk.sv
module rx_evt_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       flag2,
  input logic       slave,
  input logic [7:0] lat,
  input logic [7:0] set_vec,
  input logic [7:0] clr,
  input logic [7:0] stat_b,
  input logic [7:0] en_a,
  input logic [7:0] en_b,
  input logic       err,
  input logic       irq_n
);

  assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lat & $past(lat & ~clr)) == $past(lat & ~clr)));

  assert_set_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lat & $past(set_vec)) == $past(set_vec)));

  assert_flag2_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag2) |=> lat[2]);

  assert_flag2_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag2 && $past(flag2) && !lat[2]) |=> !lat[2]);

  assert_slip_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave && !lat[3]) |=> !lat[3]);

  assert_err_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ((stat_b != 8'h00) && (en_b != 8'h00)));

  assert_irq_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> ((en_a != 8'h00) || (en_b != 8'h00)));

  assert_rsv_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a[7] == 1'b0) && (en_b[7:5] == 3'b000));

endmodule

bind rx_evt_regs rx_evt_regs_chk u_chk (
  .clk     (clk_i),
  .rst_n   (rst_ni),
  .flag2   (flag2_i),
  .slave   (slave_i),
  .lat     (lat_w),
  .set_vec (set_w),
  .clr     (clr_w),
  .stat_b  (stat_b_w),
  .en_a    (en_a_w),
  .en_b    (en_b_w),
  .err     (err_o),
  .irq_n   (irq_no)
);

// File: tb/rx_evt_regs_bench.sv
module rx_evt_regs_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_wr = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic flag0 = 0, flag1 = 0, flag2 = 0, slip = 0, slave = 0, crc = 0, cschg = 0;
  logic par = 0, code = 0, valid = 0, unlock = 0, conf = 0;
  logic err, irq_n;
  int   n_run = 0, n_fail = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  rx_evt_regs u_rx_evt_regs (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_wr_i(rd_wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .flag0_i(flag0), .flag1_i(flag1),
    .flag2_i(flag2), .slip_i(slip), .slave_i(slave), .crc_err_i(crc),
    .cs_chg_i(cschg), .parity_err_i(par), .code_err_i(code), .validity_i(valid),
    .unlock_i(unlock), .conf_err_i(conf), .err_o(err), .irq_no(irq_n)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    cs_n = 0; rd_wr = 0; addr = a; wdata = d;
    tick();
    cs_n = 1; rd_wr = 1;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    cs_n = 0; rd_wr = 1; addr = a;
    @(negedge clk); d = rdata;
    tick();
    cs_n = 1;
    tick();
  endtask

  task automatic pins(input string req, input logic exp_irq_n, input logic exp_err);
    @(negedge clk);
    check({req, " irq_n"}, {7'b0, irq_n}, {7'b0, exp_irq_n});
    check({req, " err"}, {7'b0, err}, {7'b0, exp_err});
    tick();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    @(negedge clk);
    check("R10 idle rdata", rdata, 8'h00);
    tick();
    pins("R1", 1'b1, 1'b0);
    bus_read(3'd0, d); check("R1 status A", d, 8'h00);
    bus_read(3'd4, d); check("R1 enable A", d, 8'h00);
    bus_read(3'd5, d); check("R1 enable B", d, 8'h00);
  endtask

  task automatic t_masked();
    logic [7:0] d;
    crc = 1; tick(); crc = 0;
    pins("R9 masked", 1'b1, 1'b0);
    bus_read(3'd0, d); check("R2 crc latched", d, 8'h10);
    bus_read(3'd0, d); check("R3 cleared by read", d, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    bus_write(3'd4, 8'h10);
    cschg = 1; tick(); cschg = 0;
    tick(); tick();
    bus_read(3'd0, d); check("R2 cs change stays", d, 8'h20);
    crc = 1; tick(); crc = 0;
    pins("R9 enabled crc", 1'b0, 1'b0);
    bus_read(3'd0, d); check("R2 crc read", d, 8'h10);
    pins("R9 released after read", 1'b1, 1'b0);
  endtask

  task automatic t_read_race();
    logic [7:0] d;
    bus_write(3'd4, 8'h18);
    slave = 1;
    crc = 1; tick(); crc = 0;
    cs_n = 0; rd_wr = 1; addr = 3'd0;
    tick();
    slip = 1;
    @(negedge clk); check("R3 frozen view", rdata, 8'h10);
    tick();
    slip = 0; cs_n = 1;
    tick();
    pins("R3 new event keeps irq", 1'b0, 1'b0);
    bus_read(3'd0, d); check("R3 slip survives", d, 8'h08);
    pins("R3 all cleared", 1'b1, 1'b0);
    bus_write(3'd4, 8'h00);
  endtask

  task automatic t_flag2();
    logic [7:0] d;
    bus_write(3'd4, 8'h04);
    flag2 = 1; tick();
    pins("R4 rise", 1'b0, 1'b0);
    tick();
    bus_read(3'd0, d); check("R4 latched", d, 8'h04);
    pins("R4 steady high no relatch", 1'b1, 1'b0);
    bus_read(3'd0, d); check("R4 stays clear", d, 8'h00);
    flag2 = 0; tick(); flag2 = 1; tick();
    pins("R4 second rise", 1'b0, 1'b0);
    flag2 = 0;
    bus_read(3'd0, d); check("R4 second latch", d, 8'h04);
    bus_write(3'd4, 8'h00);
  endtask

  task automatic t_slip();
    logic [7:0] d;
    slave = 0; slip = 1; tick(); slip = 0; tick();
    bus_read(3'd0, d); check("R5 master ignored", d, 8'h00);
    slave = 1; slip = 1; tick(); slip = 0; tick();
    bus_read(3'd0, d); check("R5 slave recorded", d, 8'h08);
    slave = 0;
  endtask

  task automatic t_levels();
    logic [7:0] d;
    flag0 = 1; flag1 = 1; tick();
    bus_read(3'd0, d); check("R6 live flags", d, 8'h03);
    bus_read(3'd0, d); check("R6 not cleared", d, 8'h03);
    bus_write(3'd4, 8'h01);
    pins("R9 level flag", 1'b0, 1'b0);
    flag0 = 0;
    pins("R9 level drop", 1'b1, 1'b0);
    flag1 = 0;
    bus_write(3'd4, 8'h00);
  endtask

  task automatic t_errors();
    logic [7:0] d;
    bus_write(3'd5, 8'h09);
    valid = 1;
    pins("R8 unmasked validity", 1'b1, 1'b0);
    bus_read(3'd1, d); check("R7 validity", d, 8'h04);
    unlock = 1;
    pins("R8 unlock enabled", 1'b0, 1'b1);
    bus_read(3'd0, d); check("R8 mirror bit", d, 8'h40);
    bus_write(3'd5, 8'h00);
    pins("R8 mask off", 1'b1, 1'b0);
    valid = 0; unlock = 0;
    par = 1; code = 1; conf = 1; tick();
    bus_read(3'd1, d); check("R7 status B bits", d, 8'h13);
    par = 0; code = 0; conf = 0;
  endtask

  task automatic t_map();
    logic [7:0] d;
    bus_write(3'd4, 8'hFF);
    bus_read(3'd4, d); check("R11 enable A reserved", d, 8'h7F);
    bus_write(3'd5, 8'hFF);
    bus_read(3'd5, d); check("R11 enable B reserved", d, 8'h1F);
    bus_write(3'd0, 8'hAA);
    bus_read(3'd4, d); check("R10 status write ignored", d, 8'h7F);
    bus_write(3'd2, 8'h55);
    bus_read(3'd2, d); check("R10 unused address", d, 8'h00);
    bus_read(3'd5, d); check("R10 enable B intact", d, 8'h1F);
    bus_write(3'd4, 8'h00); bus_write(3'd5, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    t_reset();
    t_masked();
    t_irq();
    t_read_race();
    t_flag2();
    t_slip();
    t_levels();
    t_errors();
    t_map();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule